// File: doc/BRIEF.md
# LED and Stop Output Controller

This block owns the indicator side of a small playback controller. It drives two LED pins and five stop/status pins. Two mode registers and a stop register, loaded through a single-cycle write port, set how the pins behave. Three status inputs come from the rest of the chip: playback busy, a section LED request and a volume-above-threshold flag. A divider built from the clock frequency produces a roughly 3 Hz square wave. The LEDs either blink with it or stay steadily lit while requested. When both blink, they blink in phase or in opposite phases.

Two pins are shared. One carries either the second LED or stop line C. The other carries either stop line A or the busy flag for a host processor. The remaining stop lines, B, D and E, always follow their stop register bits. All register fields take effect in the cycle after the write edge. Status inputs reach the pins without a register in between.

Top module: `led_stop_ctrl`

## Requirements
- R1: While reset is held and after it is released, every control field reads 1 and all five stop bits read 1, so the outputs follow the rules below with those values.
- R2: A write with select 0 loads mode register 0, select 1 loads mode register 1, and select 2 loads stop register bits 4..0. Each load is visible on the pins from the clock edge that samples it. Select 3 changes nothing.
- R3: The flash phase is high for the first HALF = CLK_HZ/(2*FLASH_HZ) cycles after reset and then toggles every HALF cycles, giving a 50% duty square wave.
- R4: Mode0 bit 7 set makes a requested LED follow the flash phase. With the bit clear, a requested LED is steadily on. An LED that is not requested is off.
- R5: Mode0 bit 6 set puts LED2 on the shared pin `led2_stpc_o`. With the bit clear, that pin carries stop bit 2 (STPC).
- R6: Mode0 bit 2 set puts stop bit 0 (STPA) on `stpa_busy_o`. With the bit clear, that pin carries `busy_i`.
- R7: Mode1 bit 5 set drives LED2 with the inverted flash phase while flashing (alternate). With the bit clear, both LEDs use the same phase.
- R8: Mode1 bit 4 set makes `sect_led_i` the LED1 request. With the bit clear, `busy_i` is the LED1 request.
- R9: Mode1 bit 3 set makes `sect_led_i` the LED2 request. With the bit clear, stop bit 2 is the LED2 request.
- R10: Mode1 bit 2 clear additionally gates the LED1 request with `vol_led_i`. With the bit set, the volume flag has no effect.
- R11: Stop bits 1, 3 and 4 drive `stpb_o`, `stpd_o` and `stpe_o` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target: 0 mode0, 1 mode1, 2 stop, 3 none |
| wr_data | input | DATA_W | Write data |
| busy_i | input | 1 | Playback busy status |
| sect_led_i | input | 1 | Section LED request |
| vol_led_i | input | 1 | Volume above threshold |
| led1_o | output | 1 | LED1 drive |
| led2_stpc_o | output | 1 | LED2 or stop line C |
| stpa_busy_o | output | 1 | Stop line A or busy flag |
| stpb_o | output | 1 | Stop line B |
| stpd_o | output | 1 | Stop line D |
| stpe_o | output | 1 | Stop line E |

## Verification
A register write sampled at one rising edge shows on the pins before the next falling edge. The three status inputs affect the pins within the same cycle. The flash phase changes exactly HALF rising edges after the previous change, counted from reset release. The bench's behavioural model applies writes at the same rising edge as the design and counts edges since reset to derive the phase. It compares all six pins at every falling edge, after input changes have settled and before the next write lands.

// File: rtl/led_stop_pkg.sv
package led_stop_pkg;

   typedef enum logic [1:0] {
      SEL_MODE0 = 2'd0,
      SEL_MODE1 = 2'd1,
      SEL_STOP  = 2'd2,
      SEL_NONE  = 2'd3
   } wr_sel_e;

   localparam int NUM_STOP = 5;

   // bit positions decoded from the mode registers
   localparam int M0_FLASH   = 7;
   localparam int M0_LED2PIN = 6;
   localparam int M0_STPAPIN = 2;
   localparam int M1_ALT     = 5;
   localparam int M1_L1SECT  = 4;
   localparam int M1_L2SECT  = 3;
   localparam int M1_VOLOFF  = 2;

   // stop register bit order follows pin letters A..E
   localparam int ST_A = 0;
   localparam int ST_B = 1;
   localparam int ST_C = 2;
   localparam int ST_D = 3;
   localparam int ST_E = 4;

   typedef struct packed {
      logic flash;
      logic led2_pin;
      logic stpa_pin;
      logic alt;
      logic l1_sect;
      logic l2_sect;
      logic vol_off;
   } ctrl_t;

   localparam ctrl_t CTRL_RESET = '{default: 1'b1};

endpackage

// File: rtl/lsc_regs.sv
module lsc_regs
   import led_stop_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [1:0]          wr_sel,
   input  logic [DATA_W-1:0]   wr_data,
   output ctrl_t               ctrl_o,
   output logic [NUM_STOP-1:0] stop_o
);

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("lsc_regs: DATA_W must be at least 8");
      end
      if (DATA_W > 8) begin : g_wide
         logic unused_hi;
         assign unused_hi = ^wr_data[DATA_W-1:8];
      end
   endgenerate

   ctrl_t               ctrl_q;
   logic [NUM_STOP-1:0] stop_q;
   wr_sel_e             sel;

   assign sel = wr_sel_e'(wr_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RESET;
         stop_q <= '1;
      end else if (wr_en) begin
         unique case (sel)
            SEL_MODE0: begin
               ctrl_q.flash    <= wr_data[M0_FLASH];
               ctrl_q.led2_pin <= wr_data[M0_LED2PIN];
               ctrl_q.stpa_pin <= wr_data[M0_STPAPIN];
            end
            SEL_MODE1: begin
               ctrl_q.alt     <= wr_data[M1_ALT];
               ctrl_q.l1_sect <= wr_data[M1_L1SECT];
               ctrl_q.l2_sect <= wr_data[M1_L2SECT];
               ctrl_q.vol_off <= wr_data[M1_VOLOFF];
            end
            SEL_STOP: stop_q <= wr_data[NUM_STOP-1:0];
            default: ;
         endcase
      end
   end

   assign ctrl_o = ctrl_q;
   assign stop_o = stop_q;

   assert_stop_load_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_STOP) |=> stop_q == $past(wr_data[NUM_STOP-1:0]));

   assert_none_sel_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_NONE) |=> (stop_q == $past(stop_q) && ctrl_q == $past(ctrl_q)));

endmodule

// File: rtl/lsc_flash_div.sv
module lsc_flash_div #(
   parameter int CLK_HZ   = 1200,
   parameter int FLASH_HZ = 3
) (
   input  logic clk,
   input  logic rst_n,
   output logic phase_o
);

   localparam int HALF  = CLK_HZ / (2 * FLASH_HZ);
   localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

   generate
      if (FLASH_HZ < 1 || CLK_HZ < 2 * FLASH_HZ) begin : g_bad_rate
         $error("lsc_flash_div: CLK_HZ must be at least twice FLASH_HZ");
      end

      if (HALF <= 1) begin : g_toggle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) phase_o <= 1'b1;
            else        phase_o <= ~phase_o;
         end
      end else begin : g_count
         logic [CNT_W-1:0] cnt;
         logic             wrap;

         assign wrap = (cnt == CNT_W'(HALF - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt     <= '0;
               phase_o <= 1'b1;
            end else if (wrap) begin
               cnt     <= '0;
               phase_o <= ~phase_o;
            end else begin
               cnt     <= cnt + 1'b1;
            end
         end

         assert_cnt_range_R3 : assert property (@(posedge clk) disable iff (!rst_n)
            cnt < CNT_W'(HALF));

         assert_toggle_at_wrap_R3 : assert property (@(posedge clk) disable iff (!rst_n)
            (phase_o != $past(phase_o)) |-> ($past(cnt) == CNT_W'(HALF - 1)));
      end
   endgenerate

endmodule

// File: rtl/lsc_pin_mux.sv
module lsc_pin_mux
   import led_stop_pkg::*;
(
   input  ctrl_t               ctrl_i,
   input  logic [NUM_STOP-1:0] stop_i,
   input  logic                phase_i,
   input  logic                busy_i,
   input  logic                sect_i,
   input  logic                vol_i,
   output logic                led1_o,
   output logic                led2_stpc_o,
   output logic                stpa_busy_o,
   output logic [2:0]          direct_o
);

   logic req1, req2, ph2, led2;

   always_comb begin
      req1 = ctrl_i.l1_sect ? sect_i : busy_i;
      if (!ctrl_i.vol_off) req1 = req1 & vol_i;
      req2 = ctrl_i.l2_sect ? sect_i : stop_i[ST_C];
      ph2  = ctrl_i.alt ? ~phase_i : phase_i;
      led1_o = req1 & (~ctrl_i.flash | phase_i);
      led2   = req2 & (~ctrl_i.flash | ph2);
      led2_stpc_o = ctrl_i.led2_pin ? led2 : stop_i[ST_C];
      stpa_busy_o = ctrl_i.stpa_pin ? stop_i[ST_A] : busy_i;
   end

   localparam int DIRECT_IDX [3] = '{ST_B, ST_D, ST_E};

   generate
      for (genvar i = 0; i < 3; i++) begin : g_direct
         assign direct_o[i] = stop_i[DIRECT_IDX[i]];
      end
   endgenerate

endmodule

// File: rtl/led_stop_ctrl.sv
module led_stop_ctrl
   import led_stop_pkg::*;
#(
   parameter int CLK_HZ   = 1200,
   parameter int FLASH_HZ = 3,
   parameter int DATA_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              busy_i,
   input  logic              sect_led_i,
   input  logic              vol_led_i,
   output logic              led1_o,
   output logic              led2_stpc_o,
   output logic              stpa_busy_o,
   output logic              stpb_o,
   output logic              stpd_o,
   output logic              stpe_o
);

   ctrl_t               ctrl;
   logic [NUM_STOP-1:0] stop;
   logic                phase;
   logic [2:0]          direct;

   lsc_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .ctrl_o(ctrl), .stop_o(stop)
   );

   lsc_flash_div #(.CLK_HZ(CLK_HZ), .FLASH_HZ(FLASH_HZ)) u_div (
      .clk(clk), .rst_n(rst_n), .phase_o(phase)
   );

   lsc_pin_mux u_mux (
      .ctrl_i(ctrl), .stop_i(stop), .phase_i(phase), .busy_i(busy_i),
      .sect_i(sect_led_i), .vol_i(vol_led_i), .led1_o(led1_o),
      .led2_stpc_o(led2_stpc_o), .stpa_busy_o(stpa_busy_o), .direct_o(direct)
   );

   assign stpb_o = direct[0];
   assign stpd_o = direct[1];
   assign stpe_o = direct[2];

   assert_busy_pin_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.stpa_pin |-> (stpa_busy_o == busy_i));

   assert_alt_opposite_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.flash && ctrl.alt && ctrl.led2_pin && ctrl.l1_sect && ctrl.l2_sect
       && ctrl.vol_off && sect_led_i) |-> (led1_o != led2_stpc_o));

   assert_steady_led1_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.flash && ctrl.l1_sect && ctrl.vol_off) |-> (led1_o == sect_led_i));

   assert_direct_stop_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      {stpb_o, stpd_o, stpe_o} == {stop[ST_B], stop[ST_D], stop[ST_E]});

endmodule

// File: tb/led_stop_ctrl_bench.sv
module led_stop_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int CLK_HZ     = 1200;
   localparam int FLASH_HZ   = 3;
   localparam int HALF       = CLK_HZ / (2 * FLASH_HZ);

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic       busy_i = 1'b0, sect_led_i = 1'b0, vol_led_i = 1'b0;
   logic       led1_o, led2_stpc_o, stpa_busy_o, stpb_o, stpd_o, stpe_o;

   int    vectors = 0;
   int    errors  = 0;
   bit    done    = 1'b0;
   string cur_req = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   led_stop_ctrl #(.CLK_HZ(CLK_HZ), .FLASH_HZ(FLASH_HZ), .DATA_W(8)) u_led_stop_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .busy_i(busy_i), .sect_led_i(sect_led_i), .vol_led_i(vol_led_i),
      .led1_o(led1_o), .led2_stpc_o(led2_stpc_o), .stpa_busy_o(stpa_busy_o),
      .stpb_o(stpb_o), .stpd_o(stpd_o), .stpe_o(stpe_o)
   );

   // behavioural reference: register images and edges since reset
   logic [7:0] m0, m1;
   logic [4:0] st;
   int         edges;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m0 = 8'hFF; m1 = 8'hFF; st = 5'h1F; edges = 0;
      end else begin
         edges = edges + 1;
         if (wr_en) begin
            if (wr_sel == 2'd0)      m0 = wr_data;
            else if (wr_sel == 2'd1) m1 = wr_data;
            else if (wr_sel == 2'd2) st = wr_data[4:0];
         end
      end
   end

   task automatic check_pin(string pin, logic got, logic exp);
      vectors++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %b expected %b at edge %0d", cur_req, pin, got, exp, edges);
      end
   endtask

   task automatic compare();
      bit ph, r1, r2, p2, e1, e2;
      ph = ((edges / HALF) % 2) == 0;            // R3
      r1 = m1[4] ? sect_led_i : busy_i;          // R8
      if (!m1[2]) r1 = r1 && vol_led_i;          // R10
      r2 = m1[3] ? sect_led_i : st[2];           // R9
      p2 = m1[5] ? !ph : ph;                     // R7
      e1 = r1 && (!m0[7] || ph);                 // R4
      e2 = r2 && (!m0[7] || p2);
      check_pin("led1_o", led1_o, e1);
      check_pin("led2_stpc_o", led2_stpc_o, m0[6] ? e2 : st[2]);   // R5
      check_pin("stpa_busy_o", stpa_busy_o, m0[2] ? st[0] : busy_i); // R6
      check_pin("stpb_o", stpb_o, st[1]);        // R11
      check_pin("stpd_o", stpd_o, st[3]);
      check_pin("stpe_o", stpe_o, st[4]);
   endtask

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         compare();
      end
   endtask

   task automatic wr(logic [1:0] sel, logic [7:0] data);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      step(1);
      wr_en = 1'b0;
   endtask

   initial begin
      // R1: reset values visible while held and after release
      cur_req = "R1";
      step(3);
      @(negedge clk); rst_n = 1'b1;
      sect_led_i = 1'b1; busy_i = 1'b1;
      step(5);

      // R3 / R4: flash phase over two full periods, LED1 from section request
      cur_req = "R3";
      step(4 * HALF + 7);

      // R4: steady drive, then request drops
      cur_req = "R4";
      wr(2'd0, 8'h44);
      step(20); sect_led_i = 1'b0; step(5); sect_led_i = 1'b1; step(5);
      wr(2'd0, 8'hC4);

      // R7: alternate versus synchronous around a phase change
      cur_req = "R7";
      wr(2'd1, 8'hFC);
      step(HALF + 10);
      wr(2'd1, 8'hDC);
      step(HALF);

      // R5: shared pin to STPC, with stop bit 2 toggled
      cur_req = "R5";
      wr(2'd0, 8'h84);
      wr(2'd2, 8'h1B); step(5);
      wr(2'd2, 8'h04); step(5);
      wr(2'd0, 8'hC4); step(5);

      // R6: STPA versus BUSY
      cur_req = "R6";
      wr(2'd2, 8'h1E);
      wr(2'd0, 8'hC0);
      busy_i = 1'b0; step(3); busy_i = 1'b1; step(3);
      wr(2'd0, 8'hC4); busy_i = 1'b0; step(3);

      // R8: LED1 from busy when section control is off
      cur_req = "R8";
      wr(2'd1, 8'h2C); wr(2'd0, 8'h44);
      busy_i = 1'b1; sect_led_i = 1'b0; step(4);
      busy_i = 1'b0; sect_led_i = 1'b1; step(4);

      // R9: LED2 from stop bit 2 when its section control is off
      cur_req = "R9";
      wr(2'd1, 8'h24);
      wr(2'd2, 8'h04); step(3);
      wr(2'd2, 8'h00); step(3);

      // R10: volume gate on, then off
      cur_req = "R10";
      wr(2'd1, 8'h30); sect_led_i = 1'b1;
      vol_led_i = 1'b0; step(3); vol_led_i = 1'b1; step(3);
      wr(2'd1, 8'h34); vol_led_i = 1'b0; step(3);

      // R11: direct stop pins under several patterns
      cur_req = "R11";
      wr(2'd2, 8'h0A); step(2);
      wr(2'd2, 8'h10); step(2);
      wr(2'd2, 8'hF5); step(2);

      // R2: select 3 leaves every register as it was
      cur_req = "R2";
      wr(2'd3, 8'h00); step(3);
      wr(2'd3, 8'hFF); step(3);

      // R1: a second reset restores defaults mid-flash
      cur_req = "R1";
      @(negedge clk); rst_n = 1'b0; step(2);
      @(negedge clk); rst_n = 1'b1;
      step(HALF + 3);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

endmodule